// File: doc/BRIEF.md
# Serial Flash Command Decoder

This block is the command front end of a serial data-flash slave. The host lowers an active-low select and clocks an opcode into the block, most significant bit first, in SPI mode 3. Any address, dummy or data bytes follow the opcode. On the same clock the block returns response bytes. The status byte, the identification bytes, the per-sector lockdown map and a 128-byte security register can be read this way. Four-byte magic sequences change the software protection state, the one-time page-size setting and the sector lockdown bits.

A stub erase command stands in for the memory array. When it is accepted it holds a busy flag for a fixed number of cycles. The hardware write-protect pin, the software protection state and the lockdown bits can each refuse that erase. The first half of the security register can be written only once. The second half is a computed factory pattern. All serial inputs are sampled in the system clock domain, and edges are found by comparing with the previous sample.

Top module: `sfd_top`

## Requirements
- R1: The port works in SPI mode 3 with the most significant bit first. A response bit is driven after each falling edge of `sclk` and is valid at the next rising edge. `miso` is 0 while `cs_n` is high.
- R2: Opcode D7h returns the status byte on every following byte of the frame. Status bit 7 is ready (1 when not busy), bit 1 is software protection on, and bit 0 is 1024-byte pages. All other bits are 0. After reset the status byte is 82h.
- R3: Opcode 9Fh returns the four bytes of `ID_WORD`, most significant byte first. With the default these are 1Fh 28h 01h 00h. Any further byte reads 00h.
- R4: Opcode 35h followed by three dummy bytes returns one byte per sector, sector 0 first. A locked sector reads FFh and an unlocked sector reads 00h. Bytes past the last of the 8 sectors read 00h.
- R5: The frame 3Dh 2Ah 7Fh 9Ah clears software protection. The frame 3Dh 2Ah 7Fh A9h sets it. A frame with any other byte in these positions, or a frame cut short by `cs_n` rising, leaves the state unchanged.
- R6: Opcode 81h with three address bytes starts an erase of the sector given by the low 3 bits of the first address byte. An accepted erase clears ready for `BUSY_CYC` cycles. The erase is refused if any of these holds:
  - the sector is locked;
  - the sector is among sectors 0–3 and protection is on;
  - the sector is among sectors 0–3 and `wp_n` is low;
  - the block is busy.
- R7: The frame 3Dh 2Ah 80h A6h sets status bit 0. Once set, bit 0 cannot be cleared by any frame.
- R8: The frame 3Dh 2Ah 7Fh 30h followed by a sector number below 8 locks that sector permanently. An erase of a locked sector is always refused.
- R9: Opcode 77h followed by three dummy bytes returns security bytes 0, 1, 2 and onward. User bytes 0–63 read FFh until they are programmed.
- R10: Opcode 9Bh followed by three dummy bytes writes the next data bytes into user bytes 0, 1 and onward. After one frame has written at least one byte, later program frames change nothing. Bytes 64–127 always read (37·i + 5Ah) mod 256.
- R11: When `cs_n` rises in the middle of a byte, the partial byte is discarded. The next frame starts again with a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low device select from the host |
| sclk | input | 1 | Serial clock from the host, idles high |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low hardware write protect |
| miso | output | 1 | Serial response data to the host |

## Verification
The hardest case to reach is an erase that arrives while a previous erase is still running. Its only visible trace is that the busy window does not grow. The bench starts an erase on an unprotected sector and, a few hundred cycles later, sends a second erase on another sector. It then reads status at a moment after the first window has closed but before a restarted window would close, and expects ready. Lockdown, protection and write-protect refusals are observed the same way: a status read taken at once shows ready still high.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam logic [7:0] OP_STATUS  = 8'hD7;
  localparam logic [7:0] OP_IDENT   = 8'h9F;
  localparam logic [7:0] OP_LOCK_RD = 8'h35;
  localparam logic [7:0] OP_SEC_RD  = 8'h77;
  localparam logic [7:0] OP_SEC_PRG = 8'h9B;
  localparam logic [7:0] OP_ERASE   = 8'h81;

  localparam logic [31:0] SEQ_UNPROT = 32'h3D2A_7F9A;
  localparam logic [31:0] SEQ_PROT   = 32'h3D2A_7FA9;
  localparam logic [31:0] SEQ_PAGE   = 32'h3D2A_80A6;
  localparam logic [31:0] SEQ_LOCK   = 32'h3D2A_7F30;

  // fixed pattern of the upper security half
  function automatic logic [7:0] factory_byte(input logic [6:0] a);
    return 8'(32'(a) * 37) + 8'h5A;
  endfunction

  function automatic logic [7:0] pack_status(input logic rdy, input logic prot,
                                             input logic p1024);
    return {rdy, 5'b0, prot, p1024};
  endfunction

  function automatic logic [7:0] id_byte(input logic [31:0] w, input logic [1:0] n);
    return w[8*(3-int'(n)) +: 8];
  endfunction
endpackage

// File: rtl/sfd_spi_if.sv
module sfd_spi_if (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       frame_end
);
  logic       sclk_q, cs_q;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic       sclk_rise, sclk_fall;

  assign sclk_rise = sclk & ~sclk_q & ~cs_n;
  assign sclk_fall = ~sclk & sclk_q & ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cs_q <= 1'b1;
      bit_cnt <= '0;
      rx_sh <= '0;
      tx_sh <= '0;
      miso <= 1'b0;
      byte_done <= 1'b0;
      rx_byte <= '0;
      frame_end <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q <= cs_n;
      byte_done <= 1'b0;
      frame_end <= cs_n & ~cs_q;
      if (cs_n) begin
        bit_cnt <= '0;
        miso <= 1'b0;
      end else begin
        if (sclk_rise) begin
          rx_sh <= {rx_sh[6:0], mosi};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte <= {rx_sh[6:0], mosi};
          end
        end
        if (sclk_fall) begin
          if (bit_cnt == 3'd0) begin
            miso <= tx_byte[7];
            tx_sh <= {tx_byte[6:0], 1'b0};
          end else begin
            miso <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfd_cmd.sv
module sfd_cmd
  import sfd_pkg::*;
#(
  parameter int N_SECT = 8,
  parameter logic [31:0] ID_WORD = 32'h1F28_0100,
  parameter int BUSY_CYC = 600,
  parameter logic [N_SECT-1:0] PROT_MASK = 'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              byte_done,
  input  logic              frame_end,
  input  logic [7:0]        rx_byte,
  output logic [7:0]        tx_byte,
  output logic              erase_go,
  output logic              erase_rej,
  output logic              ready,
  output logic              prot_en,
  output logic              page1024,
  output logic [N_SECT-1:0] lock
);
  localparam int SW = (N_SECT > 1) ? $clog2(N_SECT) : 1;
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam int SEC_USER = 64;

  logic [7:0]  idx, opcode;
  logic [31:0] seq;
  logic        otp_done, otp_wr;
  logic [CW-1:0] busy_cnt;
  logic [7:0]  user_mem [SEC_USER];

  logic [31:0] word4;
  logic [7:0]  rofs, addr_hi;
  logic        at_seq4, unprot_hit, prot_hit, page_hit, lock_hit, erase_cmd;
  logic        erase_block, sec_wr;
  logic [SW-1:0] erase_sec, lock_sel;
  logic [N_SECT-1:0] lock_set;

  assign word4      = {seq[23:0], rx_byte};
  assign rofs       = idx - 8'd4;
  assign addr_hi    = seq[15:8];
  assign at_seq4    = byte_done && (idx == 8'd3);
  assign unprot_hit = at_seq4 && (word4 == SEQ_UNPROT);
  assign prot_hit   = at_seq4 && (word4 == SEQ_PROT);
  assign page_hit   = at_seq4 && (word4 == SEQ_PAGE);
  assign lock_sel   = rx_byte[SW-1:0];
  assign lock_hit   = byte_done && (idx == 8'd4) && (seq == SEQ_LOCK) &&
                      (32'(rx_byte) < N_SECT);
  assign erase_cmd  = at_seq4 && (seq[23:16] == OP_ERASE);
  assign erase_sec  = addr_hi[SW-1:0];
  assign ready      = (busy_cnt == '0);
  assign erase_block = lock[erase_sec] | (PROT_MASK[erase_sec] & (prot_en | ~wp_n));
  assign erase_go   = erase_cmd & ~erase_block & ready;
  assign erase_rej  = erase_cmd & ~erase_go;
  assign sec_wr     = byte_done && (opcode == OP_SEC_PRG) && (idx >= 8'd4) &&
                      (rofs < 8'(SEC_USER)) && !otp_done;

  for (genvar s = 0; s < N_SECT; s++) begin : g_lock
    assign lock_set[s] = lock_hit && (lock_sel == SW'(s));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      opcode <= '0;
      seq <= '0;
      prot_en <= 1'b1;
      page1024 <= 1'b0;
      lock <= '0;
      busy_cnt <= '0;
      otp_done <= 1'b0;
      otp_wr <= 1'b0;
      for (int i = 0; i < SEC_USER; i++) user_mem[i] <= 8'hFF;
    end else begin
      if (cs_n) idx <= '0;
      else if (byte_done && idx != 8'hFF) idx <= idx + 8'd1;
      if (byte_done && idx == 8'd0) opcode <= rx_byte;
      if (byte_done && idx < 8'd4) seq <= word4;
      if (unprot_hit) prot_en <= 1'b0;
      if (prot_hit) prot_en <= 1'b1;
      if (page_hit) page1024 <= 1'b1;
      lock <= lock | lock_set;
      if (erase_go) busy_cnt <= CW'(BUSY_CYC);
      else if (!ready) busy_cnt <= busy_cnt - 1'b1;
      if (sec_wr) begin
        user_mem[rofs[5:0]] <= rx_byte;
        otp_wr <= 1'b1;
      end
      if (frame_end) begin
        otp_done <= otp_done | otp_wr;
        otp_wr <= 1'b0;
      end
    end
  end

  always_comb begin
    tx_byte = '0;
    if (idx != 8'd0) begin
      case (opcode)
        OP_STATUS: tx_byte = pack_status(ready, prot_en, page1024);
        OP_IDENT:  if (idx <= 8'd4) tx_byte = id_byte(ID_WORD, 2'(idx - 8'd1));
        OP_LOCK_RD:
          if (idx >= 8'd4 && 32'(rofs) < N_SECT) tx_byte = {8{lock[rofs[SW-1:0]]}};
        OP_SEC_RD:
          if (idx >= 8'd4 && rofs < 8'd128)
            tx_byte = (rofs < 8'(SEC_USER)) ? user_mem[rofs[5:0]] : factory_byte(rofs[6:0]);
        default: tx_byte = '0;
      endcase
    end
  end
endmodule

// File: rtl/sfd_top.sv
module sfd_top #(
  parameter int N_SECT = 8,
  parameter logic [31:0] ID_WORD = 32'h1F28_0100,
  parameter int BUSY_CYC = 600,
  parameter logic [N_SECT-1:0] PROT_MASK = 'h0F
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  logic [7:0] tx_byte, rx_byte;
  logic byte_done, frame_end;
  logic erase_go, erase_rej, ready, prot_en, page1024;
  logic [N_SECT-1:0] lock_bits;

  sfd_spi_if u_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .tx_byte(tx_byte), .miso(miso), .byte_done(byte_done),
    .rx_byte(rx_byte), .frame_end(frame_end)
  );

  sfd_cmd #(.N_SECT(N_SECT), .ID_WORD(ID_WORD), .BUSY_CYC(BUSY_CYC),
            .PROT_MASK(PROT_MASK)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .byte_done(byte_done), .frame_end(frame_end), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .erase_go(erase_go), .erase_rej(erase_rej),
    .ready(ready), .prot_en(prot_en), .page1024(page1024), .lock(lock_bits)
  );
endmodule

// File: rtl/sfd_chk.sv
module sfd_chk #(parameter int N_SECT = 8) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic miso,
  input logic erase_go,
  input logic erase_rej,
  input logic ready,
  input logic page1024,
  input logic [N_SECT-1:0] lock
);
  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> !miso);
  // R6
  erase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) erase_go |-> ready);
  // R6
  erase_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) erase_go |=> !ready);
  // R6
  erase_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_rej && ready) |=> ready);
  // R7
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) page1024 |=> page1024);
  // R8
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock & $past(lock)) == $past(lock)));
endmodule

bind sfd_top sfd_chk #(.N_SECT(N_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .erase_go(erase_go),
  .erase_rej(erase_rej), .ready(ready), .page1024(page1024), .lock(lock_bits)
);

// File: tb/sfd_top_tb_top.sv
module sfd_top_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF = 4 * CLK_P;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  wire miso;

  sfd_top dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
                 .wp_n(wp_n), .miso(miso));

  always #(CLK_P/2) clk = ~clk;

  typedef struct { bit chk; logic [7:0] exp; string req; } exp_t;
  exp_t sbq[$];
  exp_t cur;
  int n_chk = 0, n_err = 0;
  logic [7:0] got;
  logic [7:0] m_user [64];
  event got_ev;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: pops one scoreboard entry per received byte
  always @(got_ev) begin
    cur = sbq.pop_front();
    if (cur.chk) check(cur.req, got, cur.exp);
  end

  task automatic xbyte(input logic [7:0] tx, input bit chk, input logic [7:0] exp,
                       input string req);
    sbq.push_back('{chk, exp, req});
    for (int b = 7; b >= 0; b--) begin
      sclk = 1'b0; mosi = tx[b]; #HALF;
      sclk = 1'b1; got[b] = miso; #HALF;
    end
    ->got_ev;
  endtask

  task automatic cs_on(); cs_n = 1'b0; #HALF; endtask
  task automatic cs_off(); #HALF; cs_n = 1'b1; #(2*HALF); endtask
  task automatic send(input logic [7:0] b); xbyte(b, 1'b0, 8'h00, ""); endtask

  task automatic read_status(input logic [7:0] exp, input string req);
    cs_on(); send(8'hD7); xbyte(8'h00, 1'b1, exp, req); cs_off();
  endtask

  task automatic frame4(input logic [31:0] w);
    cs_on();
    for (int i = 3; i >= 0; i--) send(w[8*i +: 8]);
    cs_off();
  endtask

  task automatic erase(input logic [7:0] sec);
    cs_on(); send(8'h81); send(sec); send(8'h00); send(8'h00); cs_off();
  endtask

  task automatic lock_read(input logic [7:0] locked, input string req);
    cs_on(); send(8'h35); send(0); send(0); send(0);
    for (int s = 0; s < 8; s++) xbyte(8'h00, 1'b1, locked[s] ? 8'hFF : 8'h00, req);
    xbyte(8'h00, 1'b1, 8'h00, req);
    cs_off();
  endtask

  task automatic sec_read(input string req);
    cs_on(); send(8'h77); send(0); send(0); send(0);
    for (int i = 0; i < 128; i++)
      xbyte(8'h00, 1'b1, (i < 64) ? m_user[i] : 8'((i * 37 + 90) % 256), req);
    cs_off();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_user[i] = 8'hFF;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #HALF;
    check("R1 idle miso", {7'b0, miso}, 8'h00);

    // R2 status repeats on every byte
    cs_on(); send(8'hD7); xbyte(0, 1, 8'h82, "R2"); xbyte(0, 1, 8'h82, "R2"); cs_off();

    // R3 identification
    cs_on(); send(8'h9F);
    xbyte(0, 1, 8'h1F, "R3"); xbyte(0, 1, 8'h28, "R3");
    xbyte(0, 1, 8'h01, "R3"); xbyte(0, 1, 8'h00, "R3"); xbyte(0, 1, 8'h00, "R3");
    cs_off();

    lock_read(8'h00, "R4");

    // R5 wrong last byte, then a truncated sequence and its tail alone
    frame4(32'h3D2A_7F9B);
    read_status(8'h82, "R5 bad byte");
    cs_on(); send(8'h3D); send(8'h2A); send(8'h7F); cs_off();
    cs_on(); send(8'h9A); cs_off();
    read_status(8'h82, "R5 cut frame");

    erase(8'h01);
    read_status(8'h82, "R6 protected");
    frame4(32'h3D2A_7F9A);
    read_status(8'h80, "R5 unprotect");

    wp_n = 1'b0;
    erase(8'h02);
    read_status(8'h80, "R6 wp refuse");
    erase(8'h05);
    read_status(8'h00, "R6 busy");
    erase(8'h06);
    wp_n = 1'b1;
    repeat (200) @(negedge clk);
    read_status(8'h80, "R6 busy refuse");

    // R8 lock sector 5
    cs_on(); send(8'h3D); send(8'h2A); send(8'h7F); send(8'h30); send(8'h05); cs_off();
    lock_read(8'h20, "R8 lock map");
    erase(8'h05);
    read_status(8'h80, "R8 locked erase");

    frame4(32'h3D2A_80A6);
    read_status(8'h81, "R7 page");
    frame4(32'h3D2A_7FA9);
    read_status(8'h83, "R5 reprotect");
    frame4(32'h3D2A_80A6);
    read_status(8'h83, "R7 page again");

    sec_read("R9");

    // R10 program two bytes once
    cs_on(); send(8'h9B); send(0); send(0); send(0); send(8'hAA); send(8'h55); cs_off();
    m_user[0] = 8'hAA; m_user[1] = 8'h55;
    cs_on(); send(8'h9B); send(0); send(0); send(0); send(8'hCC); cs_off();
    sec_read("R10");

    // R11 partial byte then abort
    cs_n = 1'b0; #HALF;
    for (int b = 7; b >= 4; b--) begin
      sclk = 1'b0; mosi = b[0]; #HALF; sclk = 1'b1; #HALF;
    end
    cs_off();
    cs_on(); send(8'h9F); xbyte(0, 1, 8'h1F, "R11"); cs_off();
    check("R1 idle miso end", {7'b0, miso}, 8'h00);

    #(4*HALF);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule